// File: doc/BRIEF.md
# Cascadable Dual 16-bit Timer

The block holds two 16-bit counter channels, an upper one and a lower one. Each channel runs by itself from one of several prescaled tick enables supplied from outside, or from a two-phase quadrature input decoded at four counts per cycle. The upper channel can also be chained to the lower one. It then advances on every lower wrap, and the two counters act as one 32-bit counter, with the lower channel holding the low half.

Each channel has a 16-bit general register that can capture its counter when an edge arrives on that channel's capture pin. The pin is synchronised first, and the edge polarity is selectable. When both pins fire in the same cycle, the two registers hold one coherent 32-bit snapshot. Software reaches the control, count and general registers through a single-cycle write strobe and a combinational read mux.

The quadrature decoder is a four-state machine. Its states PH_00, PH_10, PH_11 and PH_01 name the last synchronised {A,B} level, and the state register always loads the current level. The machine has four transitions. STEP_FWD is a move to the next state in the up sequence and produces one up count. STEP_REV is a move to the previous state and produces one down count. HOLD means the level is unchanged and nothing is counted. SKIP means both inputs changed together; the state follows the inputs but nothing is counted.

Top module: `cascade_timer_pair`

## Requirements
- R1: After reset, all six registers (control, count and general for both channels) read as 0.
- R2: Address decoding: bus_addr[2] picks the channel (0 upper, 1 lower), and bus_addr[1:0] picks the register (0 control, 1 count, 2 general; 3 reads 0). The control fields are sel in [2:0], quad mode in [3], capture enable in [4], capture edge in [5] (1 means falling) and start in [6]. Control bits 15..7 are dropped on write and read as 0.
- R3: With start=1 and quad=0, sel codes 0..3 increment the counter on each cycle in which tick_en[sel] is 1. Codes 4..6 never count, and neither does code 7 on the lower channel. With start=0 the counter holds.
- R4: A write to a count register loads bus_wdata at that clock edge, overriding any count in the same cycle.
- R5: With quad=1, each pin passes through a two-flop synchroniser. A move of {A,B} along 00→10→11→01→00 counts up by one, and the reverse move counts down by one. A change of both bits at once does not count.
- R6: With upper sel=7 and quad=0, a lower wrap from 0xFFFF to 0x0000 increments the upper counter at the same clock edge. The upper counter itself wraps from 0xFFFF to 0x0000.
- R7: A lower wrap from 0x0000 to 0xFFFF, which only quad mode can produce, decrements a cascaded upper counter at the same edge.
- R8: Cascaded counting needs both start bits. A stopped upper channel ignores lower wraps, and a stopped lower channel produces none.
- R9: With the upper channel in quad mode, its sel field is ignored: lower wraps do not change it.
- R10: With capture enabled, the selected edge on the synchronised capture pin loads the general register with the count held in the cycle the edge is detected. A write to the general register wins in the same cycle. With capture disabled, nothing is loaded.
- R11: When rising edges reach both capture pins in the same cycle, the upper and lower general registers hold the two halves of the same 32-bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 4 | Prescaled tick enables, chosen by sel codes 0..3 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address (channel, register) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| hi_quad_a | input | 1 | Upper channel quadrature phase A |
| hi_quad_b | input | 1 | Upper channel quadrature phase B |
| lo_quad_a | input | 1 | Lower channel quadrature phase A |
| lo_quad_b | input | 1 | Lower channel quadrature phase B |
| hi_cap | input | 1 | Upper channel capture pin |
| lo_cap | input | 1 | Lower channel capture pin |

## Verification
The bench drives the lower counter through an overflow by ticks, then through an underflow and an overflow by quadrature steps. A design that used the wrong polarity, counted the illegal double change, or raised its wrap one cycle late would leave the upper half off by one. The bench then stops each start bit in turn and puts the upper channel in quad mode with sel still 7. A design that ignored a start bit or let sel through would then move the upper counter. The coherent-capture case times both capture edges to land in the cycle the lower counter wraps. A capture that used a stale or a future count would split the 32-bit snapshot. A long random run of ticks, quadrature walks, capture toggles and register writes is compared every few dozen cycles against a cycle model.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    localparam int SEL_W    = 3;
    localparam int SEL_SPAN = 1 << SEL_W;
    localparam logic [SEL_W-1:0] CASC_SEL = 3'd7;

    // control word, MSB first: start, edge, capture enable, quad, select
    typedef struct packed {
        logic             start;
        logic             cap_fall;
        logic             cap_en;
        logic             quad;
        logic [SEL_W-1:0] sel;
    } chan_ctrl_t;

    localparam int CTRL_W = $bits(chan_ctrl_t);

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_COUNT = 2'd1,
        REG_GEN   = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    // quadrature phase = last synchronised {A,B}
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_10 = 2'b10,
        PH_11 = 2'b11,
        PH_01 = 2'b01
    } quad_ph_e;

endpackage

// File: rtl/dtc_sync.sv
module dtc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/dtc_quad_fsm.sv
module dtc_quad_fsm
    import dtc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_a,
    input  logic pin_b,
    output logic step_up,
    output logic step_dn
);
    logic [1:0] ab_sync;
    quad_ph_e   state_q;
    quad_ph_e   cur;

    dtc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({pin_a, pin_b}),
        .dout (ab_sync)
    );

    assign cur = quad_ph_e'(ab_sync);

    // state register: always tracks the sampled level (STEP_FWD, STEP_REV, HOLD, SKIP)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_00;
        else        state_q <= cur;
    end

    // outputs: forward neighbour counts up, backward neighbour counts down
    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        unique case (state_q)
            PH_00: begin step_up = (cur == PH_10); step_dn = (cur == PH_01); end
            PH_10: begin step_up = (cur == PH_11); step_dn = (cur == PH_00); end
            PH_11: begin step_up = (cur == PH_01); step_dn = (cur == PH_10); end
            PH_01: begin step_up = (cur == PH_00); step_dn = (cur == PH_11); end
            default: ;
        endcase
    end

    // R5: a double change never produces a count
    a_r5_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_00 && cur == PH_11) |-> !(step_up || step_dn));
endmodule

// File: rtl/dtc_channel.sv
module dtc_channel
    import dtc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int NUM_TICKS   = 4,
    parameter int SYNC_STAGES = 2,
    parameter bit ALLOW_CASC  = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TICKS-1:0] tick_en,
    input  logic                 casc_up,
    input  logic                 casc_dn,
    input  logic                 wr_ctrl,
    input  logic                 wr_cnt,
    input  logic                 wr_gen,
    input  logic [CNT_W-1:0]     wdata,
    input  logic                 quad_a,
    input  logic                 quad_b,
    input  logic                 cap_pin,
    output chan_ctrl_t           ctrl_o,
    output logic [CNT_W-1:0]     cnt_o,
    output logic [CNT_W-1:0]     gen_o,
    output logic                 ovf_o,
    output logic                 unf_o
);
    chan_ctrl_t           ctrl_q;
    logic [CNT_W-1:0]     cnt_q, gen_q;
    logic [SEL_SPAN-1:0]  tick_pad;
    logic                 q_up, q_dn, up, dn, run;
    logic                 cap_s, cap_last, cap_hit;

    dtc_quad_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_quad (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_a  (quad_a),
        .pin_b  (quad_b),
        .step_up(q_up),
        .step_dn(q_dn)
    );

    dtc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_cap_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cap_pin),
        .dout (cap_s)
    );

    assign tick_pad = {{(SEL_SPAN-NUM_TICKS){1'b0}}, tick_en};
    assign run      = ctrl_q.start;

    // count source select
    always_comb begin
        up = 1'b0;
        dn = 1'b0;
        if (ctrl_q.quad) begin
            up = q_up;
            dn = q_dn;
        end else if (ctrl_q.sel == CASC_SEL) begin
            if (ALLOW_CASC) begin
                up = casc_up;
                dn = casc_dn;
            end
        end else begin
            up = tick_pad[ctrl_q.sel];
        end
    end

    assign ovf_o   = run && up && (cnt_q == {CNT_W{1'b1}}) && !wr_cnt;
    assign unf_o   = run && dn && (cnt_q == '0) && !wr_cnt;
    assign cap_hit = ctrl_q.cap_en && (ctrl_q.cap_fall ? (!cap_s && cap_last) : (cap_s && !cap_last));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            cnt_q    <= '0;
            gen_q    <= '0;
            cap_last <= 1'b0;
        end else begin
            cap_last <= cap_s;
            if (wr_ctrl) ctrl_q <= chan_ctrl_t'(wdata[CTRL_W-1:0]);
            if (wr_cnt)           cnt_q <= wdata;
            else if (run && up)   cnt_q <= cnt_q + 1'b1;
            else if (run && dn)   cnt_q <= cnt_q - 1'b1;
            if (wr_gen)           gen_q <= wdata;
            else if (cap_hit)     gen_q <= cnt_q;
        end
    end

    assign ctrl_o = ctrl_q;
    assign cnt_o  = cnt_q;
    assign gen_o  = gen_q;

    // R3: a stopped counter holds unless written
    a_r3_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.start && !wr_cnt) |=> (cnt_q == $past(cnt_q)));

    // R4: software write wins over counting
    a_r4_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_q == $past(wdata)));

    // R7: underflow only from quad decoding or a cascade feed
    a_r7_unf_source: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> (ctrl_q.quad || (ALLOW_CASC && ctrl_q.sel == CASC_SEL)));

    // R10: capture loads the count present in the detect cycle
    a_r10_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_hit && !wr_gen) |=> (gen_q == $past(cnt_q)));
endmodule

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair
    import dtc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int NUM_TICKS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TICKS-1:0] tick_en,
    input  logic                 bus_wr,
    input  logic [2:0]           bus_addr,
    input  logic [CNT_W-1:0]     bus_wdata,
    output logic [CNT_W-1:0]     bus_rdata,
    input  logic                 hi_quad_a,
    input  logic                 hi_quad_b,
    input  logic                 lo_quad_a,
    input  logic                 lo_quad_b,
    input  logic                 hi_cap,
    input  logic                 lo_cap
);
    localparam int NUM_CH = 2;
    localparam int CH_HI  = 0;
    localparam int CH_LO  = 1;

    chan_ctrl_t       ch_ctrl   [NUM_CH];
    logic [CNT_W-1:0] ch_cnt    [NUM_CH];
    logic [CNT_W-1:0] ch_gen    [NUM_CH];
    logic             ch_wr_cnt [NUM_CH];
    logic [NUM_CH-1:0] qa_v, qb_v, cap_v;
    logic             lo_ovf, lo_unf, hi_ovf, hi_unf;
    logic             hi_casc_ready;

    assign qa_v  = {lo_quad_a, hi_quad_a};
    assign qb_v  = {lo_quad_b, hi_quad_b};
    assign cap_v = {lo_cap, hi_cap};

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel_ch, wr_c, wr_n, wr_g, casc_u, casc_d, ovf_w, unf_w;

        assign sel_ch = bus_wr && (bus_addr[2] == 1'(i));
        assign wr_c   = sel_ch && (bus_addr[1:0] == REG_CTRL);
        assign wr_n   = sel_ch && (bus_addr[1:0] == REG_COUNT);
        assign wr_g   = sel_ch && (bus_addr[1:0] == REG_GEN);
        assign ch_wr_cnt[i] = wr_n;

        if (i == CH_HI) begin : g_hi_link
            assign casc_u = lo_ovf;
            assign casc_d = lo_unf;
            assign hi_ovf = ovf_w;
            assign hi_unf = unf_w;
        end else begin : g_lo_link
            assign casc_u = 1'b0;
            assign casc_d = 1'b0;
            assign lo_ovf = ovf_w;
            assign lo_unf = unf_w;
        end

        dtc_channel #(
            .CNT_W      (CNT_W),
            .NUM_TICKS  (NUM_TICKS),
            .SYNC_STAGES(SYNC_STAGES),
            .ALLOW_CASC (i == CH_HI)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_en(tick_en),
            .casc_up(casc_u),
            .casc_dn(casc_d),
            .wr_ctrl(wr_c),
            .wr_cnt (wr_n),
            .wr_gen (wr_g),
            .wdata  (bus_wdata),
            .quad_a (qa_v[i]),
            .quad_b (qb_v[i]),
            .cap_pin(cap_v[i]),
            .ctrl_o (ch_ctrl[i]),
            .cnt_o  (ch_cnt[i]),
            .gen_o  (ch_gen[i]),
            .ovf_o  (ovf_w),
            .unf_o  (unf_w)
        );
    end

    always_comb begin
        unique case (reg_sel_e'(bus_addr[1:0]))
            REG_CTRL:  bus_rdata = CNT_W'(ch_ctrl[bus_addr[2]]);
            REG_COUNT: bus_rdata = ch_cnt[bus_addr[2]];
            REG_GEN:   bus_rdata = ch_gen[bus_addr[2]];
            default:   bus_rdata = '0;
        endcase
    end

    assign hi_casc_ready = ch_ctrl[CH_HI].start && !ch_ctrl[CH_HI].quad &&
                           (ch_ctrl[CH_HI].sel == CASC_SEL);

    // R6: lower overflow bumps the upper half in the same edge
    a_r6_casc_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_ovf && hi_casc_ready && !ch_wr_cnt[CH_HI]) |=>
        (ch_cnt[CH_HI] == $past(ch_cnt[CH_HI]) + CNT_W'(1)));

    // R7: lower underflow lowers the upper half in the same edge
    a_r7_casc_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_unf && hi_casc_ready && !ch_wr_cnt[CH_HI]) |=>
        (ch_cnt[CH_HI] == $past(ch_cnt[CH_HI]) - CNT_W'(1)));

    // R8: a stopped lower channel raises no wrap
    a_r8_lo_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_ctrl[CH_LO].start |-> !(lo_ovf || lo_unf));

    // R6: the upper counter wraps to zero / all ones
    a_r6_hi_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        hi_ovf |=> (ch_cnt[CH_HI] == '0));
    a_r7_hi_unwrap: assert property (@(posedge clk) disable iff (!rst_n)
        hi_unf |=> (ch_cnt[CH_HI] == {CNT_W{1'b1}}));

    // R9: quad mode on the upper channel blocks the cascade feed
    a_r9_quad_blocks_casc: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_ctrl[CH_HI].quad && !ch_wr_cnt[CH_HI] && hi_quad_a == $past(hi_quad_a) &&
         hi_quad_b == $past(hi_quad_b) && hi_quad_a == $past(hi_quad_a, 2) &&
         hi_quad_b == $past(hi_quad_b, 2) && hi_quad_a == $past(hi_quad_a, 3) &&
         hi_quad_b == $past(hi_quad_b, 3) && $past(rst_n, 3)) |=>
        (ch_cnt[CH_HI] == $past(ch_cnt[CH_HI])));
endmodule

// File: tb/cascade_timer_pair_tb_top.sv
module cascade_timer_pair_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tick_en = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  hi_q = '0, lo_q = '0;
    logic        hi_cap = 1'b0, lo_cap = 1'b0;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    cascade_timer_pair dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hi_quad_a(hi_q[1]), .hi_quad_b(hi_q[0]),
        .lo_quad_a(lo_q[1]), .lo_quad_b(lo_q[0]),
        .hi_cap(hi_cap), .lo_cap(lo_cap)
    );

    // ---------------- reference model (index 0 upper, 1 lower) ----------------
    logic [6:0]  m_ctrl [2];
    logic [15:0] m_cnt [2], m_gen [2];
    logic [1:0]  qs1 [2], qs2 [2], qprev [2];
    logic        cs1 [2], cs2 [2], cs3 [2];
    logic        up, dn, run, wsel, wc, hit, lo_o, lo_u;
    logic [1:0]  st;

    function automatic logic [1:0] fwd(input logic [1:0] p);
        case (p)
            2'b00: return 2'b10;
            2'b10: return 2'b11;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] quad_step(input logic [1:0] p, input logic [1:0] c);
        if (c == fwd(p)) return 2'b10;
        if (fwd(c) == p) return 2'b01;
        return 2'b00;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_ctrl[c] = '0; m_cnt[c] = '0; m_gen[c] = '0;
                qs1[c] = '0; qs2[c] = '0; qprev[c] = '0;
                cs1[c] = 0; cs2[c] = 0; cs3[c] = 0;
            end
            lo_o = 0; lo_u = 0;
        end else begin
            for (int c = 1; c >= 0; c--) begin
                wsel = bus_wr && (bus_addr[2] == c[0]);
                wc   = wsel && (bus_addr[1:0] == 2'd1);
                st   = quad_step(qprev[c], qs2[c]);
                up = st[1]; dn = st[0];
                if (!m_ctrl[c][3]) begin
                    up = 0; dn = 0;
                    if (m_ctrl[c][2:0] == 3'd7) begin
                        if (c == 0) begin up = lo_o; dn = lo_u; end
                    end else if (m_ctrl[c][2:0] < 3'd4) begin
                        up = tick_en[m_ctrl[c][1:0]];
                    end
                end
                run = m_ctrl[c][6];
                if (c == 1) begin
                    lo_o = run && up && (m_cnt[1] == 16'hFFFF) && !wc;
                    lo_u = run && dn && (m_cnt[1] == 16'h0000) && !wc;
                end
                hit = m_ctrl[c][4] && (m_ctrl[c][5] ? (!cs2[c] && cs3[c]) : (cs2[c] && !cs3[c]));
                if (wsel && bus_addr[1:0] == 2'd2) m_gen[c] = bus_wdata;
                else if (hit)                      m_gen[c] = m_cnt[c];
                if (wc)               m_cnt[c] = bus_wdata;
                else if (run && up)   m_cnt[c] = m_cnt[c] + 16'd1;
                else if (run && dn)   m_cnt[c] = m_cnt[c] - 16'd1;
                if (wsel && bus_addr[1:0] == 2'd0) m_ctrl[c] = bus_wdata[6:0];
            end
            for (int c = 0; c < 2; c++) begin
                qprev[c] = qs2[c]; qs2[c] = qs1[c];
                cs3[c] = cs2[c]; cs2[c] = cs1[c];
            end
            qs1[0] = hi_q; qs1[1] = lo_q;
            cs1[0] = hi_cap; cs1[1] = lo_cap;
        end
    end

    function automatic logic [15:0] exp_rd(input logic [2:0] a);
        case (a[1:0])
            2'd0: return {9'd0, m_ctrl[a[2]]};
            2'd1: return m_cnt[a[2]];
            2'd2: return m_gen[a[2]];
            default: return 16'd0;
        endcase
    endfunction

    // ---------------- tasks ----------------
    task automatic compare(input string tag, input logic [2:0] a, input logic [15:0] e);
        n_chk++;
        if (bus_rdata !== e) begin
            n_err++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, e);
        end
    endtask

    task automatic chk(input string tag, input logic [2:0] a);
        @(negedge clk); bus_wr = 0; bus_addr = a; #1;
        compare(tag, a, exp_rd(a));
    endtask

    task automatic chk_val(input string tag, input logic [2:0] a, input logic [15:0] v);
        @(negedge clk); bus_wr = 0; bus_addr = a; #1;
        compare(tag, a, v);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic pulse_tick(input logic [3:0] t, input int n);
        @(negedge clk); tick_en = t;
        repeat (n) @(negedge clk);
        tick_en = '0;
    endtask

    task automatic set_lo_q(input logic [1:0] v);
        @(negedge clk); lo_q = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_lo_cap(input logic v);
        @(negedge clk); lo_cap = v;
        repeat (4) @(negedge clk);
    endtask

    // addresses: upper ctrl 0, count 1, gen 2; lower ctrl 4, count 5, gen 6
    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;

        for (int a = 0; a < 8; a++) if (a[1:0] != 2'd3) chk_val("R1 reset", 3'(a), 16'h0000);

        wr(3'd0, 16'hFF25); chk_val("R2 ctrl readback", 3'd0, 16'h0025);
        chk_val("R2 unused slot", 3'd3, 16'h0000);
        wr(3'd0, 16'h0000);

        wr(3'd5, 16'hFFFD); chk_val("R4 count write", 3'd5, 16'hFFFD);
        wr(3'd1, 16'h1234);
        wr(3'd0, 16'h0047);          // upper: start, cascade
        wr(3'd4, 16'h0040);          // lower: start, tick 0
        pulse_tick(4'b0001, 3);
        chk_val("R6 upper incremented", 3'd1, 16'h1235);
        chk_val("R6 lower wrapped", 3'd5, 16'h0000);

        wr(3'd0, 16'h0007);          // upper stopped
        wr(3'd5, 16'hFFFF);
        pulse_tick(4'b0001, 1);
        chk_val("R8 stopped upper holds", 3'd1, 16'h1235);
        chk_val("R8 lower wrapped", 3'd5, 16'h0000);

        wr(3'd0, 16'h0047);
        wr(3'd4, 16'h0048);          // lower quad, start
        set_lo_q(2'b01);
        chk_val("R7 lower underflow", 3'd5, 16'hFFFF);
        chk_val("R7 upper decremented", 3'd1, 16'h1234);
        set_lo_q(2'b10);
        chk_val("R5 double change ignored", 3'd5, 16'hFFFF);
        set_lo_q(2'b11);
        chk_val("R5 up step", 3'd5, 16'h0000);
        chk_val("R6 quad overflow", 3'd1, 16'h1235);

        wr(3'd0, 16'h004F);          // upper quad with sel 7
        set_lo_q(2'b10);
        chk_val("R9 lower underflow", 3'd5, 16'hFFFF);
        chk_val("R9 upper ignores sel", 3'd1, 16'h1235);

        wr(3'd4, 16'h0008);          // lower quad, stopped
        set_lo_q(2'b00);
        chk_val("R3 stopped holds", 3'd5, 16'hFFFF);
        wr(3'd4, 16'h0045);
        pulse_tick(4'b1111, 5);
        chk_val("R3 code 5 idle", 3'd5, 16'hFFFF);
        wr(3'd4, 16'h0047);
        pulse_tick(4'b1111, 3);
        chk_val("R3 lower code 7 idle", 3'd5, 16'hFFFF);
        wr(3'd4, 16'h0042);
        pulse_tick(4'b0100, 3);
        chk_val("R3 code 2 counts", 3'd5, 16'h0002);

        wr(3'd6, 16'h0000);
        wr(3'd4, 16'h0050);
        wr(3'd5, 16'hABCD);
        set_lo_cap(1'b1);
        chk_val("R10 rising capture", 3'd6, 16'hABCD);
        wr(3'd4, 16'h0070);
        wr(3'd5, 16'h1111);
        set_lo_cap(1'b0);
        chk_val("R10 falling capture", 3'd6, 16'h1111);
        wr(3'd4, 16'h0040);
        wr(3'd5, 16'h2222);
        set_lo_cap(1'b1);
        chk_val("R10 disabled no capture", 3'd6, 16'h1111);

        set_lo_cap(1'b0);
        wr(3'd0, 16'h0057);
        wr(3'd4, 16'h0050);
        wr(3'd5, 16'hFFFE);
        wr(3'd1, 16'h0042);
        @(negedge clk); tick_en = 4'b0001; hi_cap = 1; lo_cap = 1;
        repeat (6) @(negedge clk);
        tick_en = '0;
        chk_val("R11 upper snapshot", 3'd2, 16'h0043);
        chk_val("R11 lower snapshot", 3'd6, 16'h0000);

        // random phase: R3 R5 R6 R7 R10 R11 against the model
        for (int it = 0; it < 250; it++) begin
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                tick_en = 4'($urandom);
                case ($urandom % 8)
                    0, 1: lo_q = fwd(lo_q);
                    2, 3: lo_q = fwd(fwd(fwd(lo_q)));
                    4:    lo_q = ~lo_q;
                    default: ;
                endcase
                case ($urandom % 8)
                    0: hi_q = fwd(hi_q);
                    1: hi_q = fwd(fwd(fwd(hi_q)));
                    default: ;
                endcase
                if ($urandom % 8 == 0) hi_cap = ~hi_cap;
                if ($urandom % 8 == 0) lo_cap = ~lo_cap;
                if ($urandom % 12 == 0) begin
                    bus_wr = 1; bus_addr = 3'($urandom); bus_wdata = 16'($urandom);
                end else begin
                    bus_wr = 0;
                end
            end
            for (int a = 0; a < 8; a++)
                if (a[1:0] != 2'd3) chk("R3/R5/R6/R7/R10 random vs model", 3'(a));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule